// File: doc/BRIEF.md
# Per-Pin Output Signal Crossbar

This block sits between a GPIO register file and the pad ring. Each IO owns one configuration byte. The top bit of that byte selects GPIO mode. In GPIO mode the pad output data and output enable come straight from the GPIO register vectors. When the top bit is clear on a pin that supports routing, the low seven bits name an IO number. The pad input arriving on that IO is then copied onto this pin's output, and the pin's output enable is forced on.

Some pins have a fixed direction. On those pins the output enable holds a parameter-fixed value, whatever the configuration or GPIO state. Directions are seen from the block's side of the pads. A host transmit line therefore arrives as a pad input, and it can be forwarded to any routable pin.

Software reaches the configuration bytes through a byte-wide port. The byte for IO n sits at byte address 128 + n. Writes take effect on the clock edge. Reads are combinational.

Top module: `sig_crossbar`

## Requirements
- R1: A synchronous active-low reset loads 0x80 into every configuration byte, so after reset every pin is in GPIO mode.
- R2: A write strobe with an address of 128 + n (n below NUM_IO) stores the data byte for IO n at that clock edge. While `cfg_addr` holds 128 + n, `cfg_rdata` returns the stored byte combinationally.
- R3: On pins without routing support, bits 6:0 always read back 0 and bit 7 is stored as written. With the defaults, routing is supported on IO 1–20 and 32–80 and not on IO 0 or 21–31.
- R4: When bit 7 is 1, or the pin has no routing support, `pad_do[n]` equals `gpio_do[n]`. Unless the pin is direction-locked, `pad_oe[n]` also equals `gpio_oe[n]`.
- R5: When bit 7 is 0 on a routable pin, `pad_do[n]` equals `pad_in[s]`, where s is bits 6:0. Unless the pin is direction-locked, `pad_oe[n]` is 1.
- R6: A selector value s with s >= NUM_IO (81 by default) makes a routed pin drive 0.
- R7: On direction-locked pins, `pad_oe[n]` equals the fixed locked value no matter what the configuration or `gpio_oe` holds. By default IO 1–8, 21, 79 and 80 are locked to 0, and IO 11–20 and 22–78 are locked to 1. IO 0, 9 and 10 are not locked.
- R8: Writes to addresses below 128 or at 128 + NUM_IO and above change no configuration byte. Reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Byte address for the write and the read |
| cfg_wdata | input | 8 | Write data byte |
| cfg_rdata | output | 8 | Read data byte for `cfg_addr` |
| pad_in | input | NUM_IO | Pad input values, one per IO number |
| gpio_do | input | NUM_IO | GPIO register output data |
| gpio_oe | input | NUM_IO | GPIO register output enable |
| pad_do | output | NUM_IO | Final pad output data |
| pad_oe | output | NUM_IO | Final pad output enable |

## Verification
Some properties are checked on every cycle. One is that reset leaves every pin in GPIO mode. Another is that a written top bit is visible at once on readback. A routed pin whose selector is out of range must drive 0. A routed, unlocked pin must have its output enable asserted. Locked pins must hold their fixed enable.

Other behaviour needs the bench's scenarios and its cycle-by-cycle reference model. That covers the exact data forwarded from a chosen source while `pad_in` toggles, the masking of selector bits on unroutable pins, and writes outside the window being ignored. It also covers GPIO passthrough under changing GPIO vectors.

// File: rtl/xbar_pkg.sv
// Package: shared types and helpers for the per-pin crossbar.
// Assumes at most 128 IOs, because the selector is 7 bits wide.
package xbar_pkg;
    localparam int XB_SEL_W  = 7;
    localparam int XB_MAX_IO = 1 << XB_SEL_W;

    typedef logic [XB_MAX_IO-1:0] xb_mask_t;

    // One configuration byte: GPIO override flag plus source selector.
    typedef struct packed {
        logic                gpio_mode;
        logic [XB_SEL_W-1:0] sel;
    } xb_cfg_t;

    localparam xb_cfg_t XB_CFG_RESET = '{gpio_mode: 1'b1, sel: '0};

    // Builds a mask with bits lo..hi (inclusive) set.
    function automatic xb_mask_t xb_span(input int lo, input int hi);
        xb_mask_t m;
        m = '0;
        for (int k = 0; k < XB_MAX_IO; k++) begin
            if (k >= lo && k <= hi) m[k] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/xbar_cfg_bank.sv
// Module: configuration byte bank, one byte per IO, in the window BASE..BASE+NUM_IO-1.
// Assumes BASE + NUM_IO fits in ADDR_W bits. Selector bits are masked at write
// time on pins that have no routing support.
module xbar_cfg_bank
    import xbar_pkg::*;
#(
    parameter int       NUM_IO     = 81,
    parameter int       ADDR_W     = 8,
    parameter int       BASE       = 128,
    parameter xb_mask_t ROUTE_MASK = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [7:0]                 wdata,
    output logic [7:0]                 rdata,
    output xb_cfg_t [NUM_IO-1:0]       cfg_q
);
    localparam int IDX_W = $clog2(NUM_IO);
    localparam int LAST  = BASE + NUM_IO - 1;

    logic             hit;
    logic [IDX_W-1:0] idx;
    logic [NUM_IO-1:0] gpio_vec;

    // Decode whether the address falls in the window, and which byte it picks.
    always_comb begin
        hit = (int'(addr) >= BASE) && (int'(addr) <= LAST);
        idx = IDX_W'(addr - ADDR_W'(BASE));
    end

    for (genvar i = 0; i < NUM_IO; i++) begin : g_byte
        // Store the byte for IO i on a matching write; reset to GPIO mode.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[i] <= XB_CFG_RESET;
            end else if (we && hit && (idx == IDX_W'(i))) begin
                cfg_q[i].gpio_mode <= wdata[7];
                cfg_q[i].sel       <= ROUTE_MASK[i] ? wdata[6:0] : '0;
            end
        end
        assign gpio_vec[i] = cfg_q[i].gpio_mode;
    end

    // Return the addressed byte, or 0 outside the window.
    always_comb begin
        rdata = hit ? cfg_q[idx] : 8'h00;
    end

    // R1: reset leaves every pin in GPIO mode.
    a_r1_reset_gpio: assert property (@(posedge clk) !rst_n |=> (&gpio_vec));

    // R2: a write's top bit is visible on the next cycle's readback at the same address.
    a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit) |=> ((addr != $past(addr)) || (rdata[7] == $past(wdata[7]))));
endmodule

// File: rtl/xbar_src_select.sv
// Module: per-pin source multiplexer. Each pin picks one pad input by selector.
// Assumes the selector may exceed NUM_IO; such values yield 0.
module xbar_src_select
    import xbar_pkg::*;
#(
    parameter int NUM_IO = 81
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_IO-1:0]    src_vec,
    input  xb_cfg_t [NUM_IO-1:0] cfg_q,
    output logic [NUM_IO-1:0]    routed
);
    for (genvar i = 0; i < NUM_IO; i++) begin : g_mux
        logic in_range;

        // Pick the source bit, forcing 0 for unimplemented IO numbers.
        always_comb begin
            in_range  = int'(cfg_q[i].sel) < NUM_IO;
            routed[i] = in_range ? src_vec[cfg_q[i].sel] : 1'b0;
        end

        // R6: an out-of-range selector drives 0.
        a_r6_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(cfg_q[i].sel) >= NUM_IO) |-> !routed[i]);
    end
endmodule

// File: rtl/xbar_pad_merge.sv
// Module: final pad drive. Chooses between GPIO and routed data per pin and
// applies direction locks to the output enable.
// Assumes the lock masks are fixed at elaboration.
module xbar_pad_merge
    import xbar_pkg::*;
#(
    parameter int       NUM_IO     = 81,
    parameter xb_mask_t ROUTE_MASK = '0,
    parameter xb_mask_t LOCK_MASK  = '0,
    parameter xb_mask_t LOCK_OE    = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  xb_cfg_t [NUM_IO-1:0] cfg_q,
    input  logic [NUM_IO-1:0]    routed,
    input  logic [NUM_IO-1:0]    gpio_do,
    input  logic [NUM_IO-1:0]    gpio_oe,
    output logic [NUM_IO-1:0]    pad_do,
    output logic [NUM_IO-1:0]    pad_oe
);
    for (genvar i = 0; i < NUM_IO; i++) begin : g_pin
        logic xbar_on;

        if (ROUTE_MASK[i]) begin : g_rt
            assign xbar_on = !cfg_q[i].gpio_mode;
        end else begin : g_fixed
            assign xbar_on = 1'b0;
        end

        // Select the data source for the pin.
        always_comb begin
            pad_do[i] = xbar_on ? routed[i] : gpio_do[i];
        end

        if (LOCK_MASK[i]) begin : g_lock
            // Hold the fixed direction.
            always_comb begin
                pad_oe[i] = LOCK_OE[i];
            end
        end else begin : g_free
            // Force the enable on when routed; otherwise follow GPIO.
            always_comb begin
                pad_oe[i] = xbar_on | gpio_oe[i];
            end
            // R5: an unlocked routable pin in crossbar mode always drives.
            if (ROUTE_MASK[i]) begin : g_chk
                a_r5_xbar_oe: assert property (@(posedge clk) disable iff (!rst_n)
                    !cfg_q[i].gpio_mode |-> pad_oe[i]);
            end
        end
    end
endmodule

// File: rtl/sig_crossbar.sv
// Module: top of the per-pin output crossbar. Holds the config bank, the
// source multiplexer and the pad merge stage.
// Assumes NUM_IO is between 2 and 128 and that BASE + NUM_IO fits in ADDR_W bits.
module sig_crossbar
    import xbar_pkg::*;
#(
    parameter int       NUM_IO     = 81,
    parameter int       ADDR_W     = 8,
    parameter int       BASE       = 128,
    parameter xb_mask_t ROUTE_MASK = xb_span(1, 20) | xb_span(32, 80),
    parameter xb_mask_t LOCK_MASK  = xb_span(1, 8) | xb_span(11, 80),
    parameter xb_mask_t LOCK_OE    = xb_span(11, 20) | xb_span(22, 78)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic [NUM_IO-1:0] pad_in,
    input  logic [NUM_IO-1:0] gpio_do,
    input  logic [NUM_IO-1:0] gpio_oe,
    output logic [NUM_IO-1:0] pad_do,
    output logic [NUM_IO-1:0] pad_oe
);
    localparam logic [NUM_IO-1:0] LOCKED  = LOCK_MASK[NUM_IO-1:0];
    localparam logic [NUM_IO-1:0] LOCKVAL = LOCK_OE[NUM_IO-1:0] & LOCK_MASK[NUM_IO-1:0];

    xb_cfg_t [NUM_IO-1:0] cfg_q;
    logic    [NUM_IO-1:0] routed;

    xbar_cfg_bank #(
        .NUM_IO(NUM_IO), .ADDR_W(ADDR_W), .BASE(BASE), .ROUTE_MASK(ROUTE_MASK)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .cfg_q(cfg_q)
    );

    xbar_src_select #(.NUM_IO(NUM_IO)) u_sel (
        .clk(clk), .rst_n(rst_n), .src_vec(pad_in), .cfg_q(cfg_q), .routed(routed)
    );

    xbar_pad_merge #(
        .NUM_IO(NUM_IO), .ROUTE_MASK(ROUTE_MASK), .LOCK_MASK(LOCK_MASK), .LOCK_OE(LOCK_OE)
    ) u_merge (
        .clk(clk), .rst_n(rst_n), .cfg_q(cfg_q), .routed(routed),
        .gpio_do(gpio_do), .gpio_oe(gpio_oe), .pad_do(pad_do), .pad_oe(pad_oe)
    );

    // R7: locked pins hold their fixed enable whatever the inputs are.
    a_r7_locked_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & LOCKED) == LOCKVAL);
endmodule

// File: tb/sig_crossbar_bench.sv
module sig_crossbar_bench;
    import xbar_pkg::*;

    localparam int NUM = 81;
    localparam int BASE = 128;
    localparam xb_mask_t RT = xb_span(1, 20) | xb_span(32, 80);
    localparam xb_mask_t LK = xb_span(1, 8) | xb_span(11, 80);
    localparam xb_mask_t LV = xb_span(11, 20) | xb_span(22, 78);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [7:0] cfg_addr = 8'h00;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic [NUM-1:0] pad_in = '0, gpio_do = '0, gpio_oe = '0;
    logic [NUM-1:0] pad_do, pad_oe;

    int checks = 0;
    int errors = 0;
    string phase = "R1";
    logic [7:0] cfg_m [NUM];
    bit done = 0;

    always #4 clk = ~clk;

    sig_crossbar u_sig_crossbar (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pad_in(pad_in),
        .gpio_do(gpio_do), .gpio_oe(gpio_oe), .pad_do(pad_do), .pad_oe(pad_oe)
    );

    // Reference model state: the raw bytes software wrote.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM; i++) cfg_m[i] = 8'h80;
        end else if (cfg_we && int'(cfg_addr) >= BASE && int'(cfg_addr) < BASE + NUM) begin
            cfg_m[int'(cfg_addr) - BASE] = cfg_wdata;
        end
    end

    task automatic compare();
        logic [NUM-1:0] edo, eoe;
        logic [7:0] erd;
        for (int i = 0; i < NUM; i++) begin
            int s;
            bit xb;
            s  = int'(cfg_m[i][6:0]);
            xb = RT[i] && !cfg_m[i][7];
            edo[i] = xb ? ((s < NUM) ? pad_in[s] : 1'b0) : gpio_do[i];
            eoe[i] = LK[i] ? LV[i] : (xb ? 1'b1 : gpio_oe[i]);
        end
        if (int'(cfg_addr) >= BASE && int'(cfg_addr) < BASE + NUM) begin
            erd = cfg_m[int'(cfg_addr) - BASE];
            if (!RT[int'(cfg_addr) - BASE]) erd = erd & 8'h80;
        end else begin
            erd = 8'h00;
        end
        checks++;
        if (pad_do !== edo) begin
            errors++;
            $display("FAIL %s pad_do actual %h expected %h", phase, pad_do, edo);
        end
        checks++;
        if (pad_oe !== eoe) begin
            errors++;
            $display("FAIL %s pad_oe actual %h expected %h", phase, pad_oe, eoe);
        end
        checks++;
        if (cfg_rdata !== erd) begin
            errors++;
            $display("FAIL %s rdata@%0d actual %h expected %h", phase, cfg_addr, cfg_rdata, erd);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = 8'(a); cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic shake(input int n);
        for (int k = 0; k < n; k++) begin
            pad_in  = NUM'({$urandom, $urandom, $urandom});
            gpio_do = NUM'({$urandom, $urandom, $urandom});
            gpio_oe = NUM'({$urandom, $urandom, $urandom});
            tick();
        end
    endtask

    initial begin
        // R1: reset state, then sweep every configuration address.
        phase = "R1";
        repeat (3) tick();
        rst_n = 1'b1;
        for (int a = BASE; a < BASE + NUM; a++) begin cfg_addr = 8'(a); tick(); end

        // R4: GPIO passthrough under changing vectors.
        phase = "R4";
        cfg_addr = 8'(BASE + 9);
        shake(20);

        // R5: routed pins follow their chosen source.
        phase = "R5";
        wr(BASE + 9, 8'h01);
        wr(BASE + 15, 8'd79);
        wr(BASE + 40, 8'h09);
        wr(BASE + 0, 8'h05);
        cfg_addr = 8'(BASE + 40);
        shake(25);

        // R6: out-of-range selectors drive 0.
        phase = "R6";
        wr(BASE + 10, 8'd100);
        wr(BASE + 50, 8'd127);
        wr(BASE + 60, 8'd81);
        shake(15);

        // R3: unroutable pin keeps only bit 7.
        phase = "R3";
        wr(BASE + 25, 8'h05);
        cfg_addr = 8'(BASE + 25); tick();
        wr(BASE + 25, 8'h85);
        shake(10);

        // R7: locked pins hold direction even when routed.
        phase = "R7";
        wr(BASE + 5, 8'h03);
        wr(BASE + 12, 8'h02);
        wr(BASE + 79, 8'h0A);
        shake(15);

        // R8: writes outside the window are ignored, reads give 0.
        phase = "R8";
        wr(0, 8'h11);
        wr(127, 8'h22);
        wr(BASE + NUM, 8'h33);
        wr(255, 8'h44);
        for (int a = 120; a < 256; a += 5) begin cfg_addr = 8'(a); tick(); end
        shake(10);

        // R2: random writes and reads across the whole address space.
        phase = "R2";
        for (int k = 0; k < 400; k++) begin
            cfg_we    = ($urandom % 3) != 0;
            cfg_addr  = 8'(($urandom % 4 == 0) ? $urandom : (BASE + $urandom % NUM));
            cfg_wdata = 8'($urandom);
            pad_in  = NUM'({$urandom, $urandom, $urandom});
            gpio_do = NUM'({$urandom, $urandom, $urandom});
            gpio_oe = NUM'({$urandom, $urandom, $urandom});
            tick();
        end
        cfg_we = 1'b0;
        for (int a = BASE; a < BASE + NUM; a++) begin cfg_addr = 8'(a); tick(); end

        // R1: a second reset restores GPIO mode everywhere.
        phase = "R1";
        rst_n = 1'b0; tick();
        rst_n = 1'b1;
        shake(10);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired in %s", phase);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule